// File: doc/BRIEF.md
# Timebase Counter With Four Comparators

This block keeps a 64-bit up-counter that advances once for every rising edge of a slow timebase tick. The tick comes from another clock and is brought into the system clock domain through a short synchronizer. Software sees the counter as two 32-bit words. Reading the low word captures the high word in the same cycle, so a read of the high word that follows returns a value that belongs with the low word already read.

There are four reference registers, each 64 bits wide. When the counter takes on the value held in one of them, a status bit for that reference is set and stays set. Each status bit has an enable bit. A global enable also gates the single interrupt line. Status bits are cleared by writing a 1 to them.

A comparison counts only in the cycle after the counter has been updated, either by a tick or by a write. Loading a reference with the value the counter already holds therefore sets nothing.

Top module: `tbase_unit`

## Requirements
- R1: After reset the counter, the captured high word, all status bits, all enable bits, the global enable and all reference values are zero, and `irq` is low.
- R2: `tick_in` passes through two synchronizer stages and then an edge detector. Each low-to-high transition of `tick_in` increments the counter by exactly one, and the new value is visible after the third rising clock edge that follows the transition. Holding `tick_in` high does not increment the counter again.
- R3: The counter is 64 bits wide. Carries propagate from the low word into the high word, and the counter wraps from all ones to zero.
- R4: A write to word address 0 replaces counter bits 31:0, and a write to word address 1 replaces bits 63:32. The new value is visible in the next cycle. If an increment falls in the same cycle as such a write, the write wins and that increment is lost.
- R5: A read of address 0 returns counter bits 31:0 and captures bits 63:32 in that same cycle. A read of address 1 returns the captured word, not the live upper half.
- R6: In the cycle after any counter update, every reference n (0 to 3) whose value equals the counter sets status bit n. Once set, a status bit stays set until it is cleared.
- R7: Writing a reference with the value the static counter already holds does not set that reference's status bit.
- R8: Status is at address 2, with bit n belonging to reference n. Writing a 1 to a bit clears it and writing 0 leaves it unchanged. If a match and a clear fall in the same cycle, the match wins.
- R9: Address 3 holds the enable bits in bits 3:0 and the global enable in bit 8. `irq` is high exactly when the global enable is set and at least one status bit is set together with its enable bit.
- R10: Reference n sits at address 4+2n (bits 31:0) and at address 5+2n (bits 63:32). Both halves and the enable register read back as written. Addresses 12 to 15 read as zero and ignore writes.
- R11: The four references act independently. Several references holding the same value all set their bits on the same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Timebase tick from the slow clock domain, asynchronous |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined maskable match interrupt |

## Verification
The counter is driven with single tick pulses and with a long held-high tick, which separates edge counting from level counting. It is also loaded with values one step below a 32-bit carry and below the 64-bit wrap, which exposes a missing carry or a narrow counter. A read of the low word, then a carry, then a read of the high word shows whether the high word was captured or read live. A counter write placed in the exact cycle of a tick edge shows which of the two wins. Matches are produced by ticking, by writing the counter and by writing a reference equal to a static counter, which separates update-qualified comparison from level comparison. A long random phase of mixed ticks and register traffic is checked cycle by cycle against a behavioural model.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [2:0] {
    RK_CNT_LO,
    RK_CNT_HI,
    RK_STAT,
    RK_IEN,
    RK_REF_LO,
    RK_REF_HI,
    RK_NONE
  } reg_kind_e;

  localparam int unsigned GLB_BIT  = 8;
  localparam int unsigned REF_BASE = 4;

  function automatic reg_kind_e decode_kind(logic [31:0] a, int unsigned nref);
    if (a == 32'd0) return RK_CNT_LO;
    if (a == 32'd1) return RK_CNT_HI;
    if (a == 32'd2) return RK_STAT;
    if (a == 32'd3) return RK_IEN;
    if (a >= REF_BASE && a < REF_BASE + 2 * nref) return a[0] ? RK_REF_HI : RK_REF_LO;
    return RK_NONE;
  endfunction

  function automatic logic [31:0] decode_ref(logic [31:0] a);
    return (a - REF_BASE) >> 1;
  endfunction

endpackage

// File: rtl/tbase_tick_sync.sv
module tbase_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] cnt_q,
  output logic                upd_q
);
  localparam int CNT_W = 2 * DATA_W;

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wr_lo | wr_hi | inc;
      if (wr_lo)      cnt_q[DATA_W-1:0]     <= wdata;
      else if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
      else if (inc)   cnt_q                 <= bump(cnt_q);
    end
  end
endmodule

// File: rtl/tbase_match.sv
module tbase_match #(
  parameter int CNT_W   = 64,
  parameter int NUM_REF = 4
) (
  input  logic                            upd,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_REF-1:0][CNT_W-1:0]   refs,
  output logic [NUM_REF-1:0]              hit
);
  for (genvar g = 0; g < NUM_REF; g++) begin : g_cmp
    assign hit[g] = upd && (cnt == refs[g]);
  end
endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
  import tbase_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REF     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int RI_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;

  function automatic logic [NUM_REF-1:0] sticky_next(logic [NUM_REF-1:0] cur,
                                                     logic [NUM_REF-1:0] clr,
                                                     logic [NUM_REF-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  reg_kind_e                        kind;
  logic [RI_W-1:0]                  ref_sel;
  logic                             wr, rd;
  logic                             wr_lo, wr_hi, rd_lo;
  logic                             tick_rise;
  logic [CNT_W-1:0]                 cnt_q;
  logic                             upd_q;
  logic [NUM_REF-1:0]               hit;
  logic [NUM_REF-1:0]               status_q;
  logic [NUM_REF-1:0]               ien_q;
  logic [NUM_REF-1:0]               clr_mask;
  logic                             glb_q;
  logic [DATA_W-1:0]                shadow_q;
  logic [NUM_REF-1:0][CNT_W-1:0]    ref_q;

  always_comb begin
    kind    = decode_kind(32'(reg_addr), NUM_REF);
    ref_sel = RI_W'(decode_ref(32'(reg_addr)));
  end

  assign wr       = reg_en & reg_we;
  assign rd       = reg_en & ~reg_we;
  assign wr_lo    = wr && (kind == RK_CNT_LO);
  assign wr_hi    = wr && (kind == RK_CNT_HI);
  assign rd_lo    = rd && (kind == RK_CNT_LO);
  assign clr_mask = (wr && kind == RK_STAT) ? reg_wdata[NUM_REF-1:0] : '0;

  tbase_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .tick_rise(tick_rise)
  );

  tbase_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (tick_rise),
    .wr_lo(wr_lo),
    .wr_hi(wr_hi),
    .wdata(reg_wdata),
    .cnt_q(cnt_q),
    .upd_q(upd_q)
  );

  tbase_match #(.CNT_W(CNT_W), .NUM_REF(NUM_REF)) u_match (
    .upd (upd_q),
    .cnt (cnt_q),
    .refs(ref_q),
    .hit (hit)
  );

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[g] <= '0;
      end else if (wr && ref_sel == RI_W'(g)) begin
        if (kind == RK_REF_LO) ref_q[g][DATA_W-1:0]     <= reg_wdata;
        if (kind == RK_REF_HI) ref_q[g][CNT_W-1:DATA_W] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      glb_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      status_q <= sticky_next(status_q, clr_mask, hit);
      if (wr && kind == RK_IEN) begin
        ien_q <= reg_wdata[NUM_REF-1:0];
        glb_q <= reg_wdata[GLB_BIT];
      end
      if (rd_lo) shadow_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (kind)
      RK_CNT_LO: reg_rdata = cnt_q[DATA_W-1:0];
      RK_CNT_HI: reg_rdata = shadow_q;
      RK_STAT:   reg_rdata[NUM_REF-1:0] = status_q;
      RK_IEN: begin
        reg_rdata[NUM_REF-1:0] = ien_q;
        reg_rdata[GLB_BIT]     = glb_q;
      end
      RK_REF_LO: reg_rdata = ref_q[ref_sel][DATA_W-1:0];
      RK_REF_HI: reg_rdata = ref_q[ref_sel][CNT_W-1:DATA_W];
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = glb_q & |(status_q & ien_q);
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int CNT_W   = 64,
  parameter int NUM_REF = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_rise,
  input logic               wr_lo,
  input logic               wr_hi,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               upd_q,
  input logic [NUM_REF-1:0] hit,
  input logic [NUM_REF-1:0] status_q,
  input logic [NUM_REF-1:0] clr_mask,
  input logic               glb_q,
  input logic               irq
);
  // R2: an edge detector pulse lasts a single cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);

  // R2, R3: a tick without a write moves the counter by exactly one
  p_inc_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rise && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2: with no tick and no write the counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_rise && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R9: the global enable gates the interrupt
  p_irq_glb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_q);

  // R9: no status means no interrupt
  p_irq_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref_chk
    // R6: a match is recorded in the next cycle
    p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> status_q[g]);

    // R6, R8: a set bit persists unless a 1 is written to it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[g] && !clr_mask[g]) |=> status_q[g]);

    // R7: a status bit only rises after a counter update
    p_rise_after_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[g]) |-> $past(upd_q));
  end
endmodule

bind tbase_unit tbase_chk #(.CNT_W(CNT_W), .NUM_REF(NUM_REF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_rise(tick_rise),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .cnt_q    (cnt_q),
  .upd_q    (upd_q),
  .hit      (hit),
  .status_q (status_q),
  .clr_mask (clr_mask),
  .glb_q    (glb_q),
  .irq      (irq)
);

// File: tb/tb_tbase_unit.sv
module tb_tbase_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  tbase_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt;
  logic        m_upd;
  logic [3:0]  m_stat, m_ien;
  logic        m_glb;
  logic [31:0] m_shadow;
  logic [63:0] m_ref [4];
  bit          m_hist [$];

  function automatic logic [31:0] m_read(logic [3:0] a);
    int ai = int'(a);
    if (ai == 0) return m_cnt[31:0];
    if (ai == 1) return m_shadow;
    if (ai == 2) return {28'd0, m_stat};
    if (ai == 3) return {23'd0, m_glb, 4'd0, m_ien};
    if (ai >= 4 && ai < 12) begin
      if (ai % 2 == 0) return m_ref[(ai - 4) / 2][31:0];
      return m_ref[(ai - 4) / 2][63:32];
    end
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_upd = 0; m_stat = '0; m_ien = '0; m_glb = 0; m_shadow = '0;
      foreach (m_ref[i]) m_ref[i] = '0;
      m_hist = '{0, 0, 0};
    end else begin
      bit         rise;
      logic [3:0] found, clr;
      bit         wcnt;
      int         ai;
      ai    = int'(reg_addr);
      rise  = m_hist[1] && !m_hist[2];
      found = '0;
      for (int n = 0; n < 4; n++) if (m_upd && m_cnt == m_ref[n]) found[n] = 1'b1;
      clr   = (reg_en && reg_we && ai == 2) ? reg_wdata[3:0] : 4'd0;
      m_stat = (m_stat & ~clr) | found;
      if (reg_en && !reg_we && ai == 0) m_shadow = m_cnt[63:32];
      wcnt = reg_en && reg_we && (ai == 0 || ai == 1);
      if (wcnt) begin
        if (ai == 0) m_cnt[31:0] = reg_wdata; else m_cnt[63:32] = reg_wdata;
      end else if (rise) begin
        m_cnt = m_cnt + 64'd1;
      end
      m_upd = wcnt || rise;
      if (reg_en && reg_we && ai == 3) begin
        m_ien = reg_wdata[3:0];
        m_glb = reg_wdata[8];
      end
      if (reg_en && reg_we && ai >= 4 && ai < 12) begin
        if (ai % 2 == 0) m_ref[(ai - 4) / 2][31:0] = reg_wdata;
        else             m_ref[(ai - 4) / 2][63:32] = reg_wdata;
      end
      m_hist.push_front(tick_in);
      void'(m_hist.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] er;
      logic        ei;
      er = m_read(reg_addr);
      ei = m_glb && |(m_stat & m_ien);
      checks += 2;
      if (reg_rdata !== er) begin
        failures++;
        $display("FAIL %s: model rdata addr=%0d actual=%h expected=%h", cur_req, reg_addr, reg_rdata, er);
      end
      if (irq !== ei) begin
        failures++;
        $display("FAIL %s: model irq actual=%b expected=%b", cur_req, irq, ei);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus(input bit we, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk); last_rd = reg_rdata;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    @(posedge clk); #1; tick_in = 1'b1;
    idle(2);
    tick_in = 1'b0;
    idle(2);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus(1'b0, a, 32'd0);
    checks++;
    if (last_rd !== exp) begin
      failures++;
      $display("FAIL %s: read addr=%0d actual=%h expected=%h", req, a, last_rd, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string req);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s: irq actual=%b expected=%b", req, irq, exp);
    end
    #1;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    cur_req = "R1";
    expect_irq(1'b0, "R1");
    expect_rd(4'd0, 32'd0, "R1");
    expect_rd(4'd1, 32'd0, "R1");
    expect_rd(4'd2, 32'd0, "R1");
    expect_rd(4'd7, 32'd0, "R1");

    // R2: single pulses, then a long high level counts once
    cur_req = "R2";
    repeat (5) pulse();
    expect_rd(4'd0, 32'd5, "R2");
    @(posedge clk); #1; tick_in = 1'b1;
    idle(10);
    tick_in = 1'b0;
    idle(4);
    expect_rd(4'd0, 32'd6, "R2");

    // R4, R3: half writes and a carry into the upper word
    cur_req = "R4";
    bus(1'b1, 4'd0, 32'hFFFF_FFFE);
    bus(1'b1, 4'd1, 32'h0000_0001);
    expect_rd(4'd0, 32'hFFFF_FFFE, "R4");
    expect_rd(4'd1, 32'h0000_0001, "R4");
    cur_req = "R3";
    repeat (3) pulse();
    expect_rd(4'd0, 32'h0000_0001, "R3");
    expect_rd(4'd1, 32'h0000_0002, "R3");

    // R5: the upper word comes from the capture at the low read
    cur_req = "R5";
    bus(1'b1, 4'd0, 32'hFFFF_FFFF);
    bus(1'b1, 4'd1, 32'h0000_0007);
    expect_rd(4'd0, 32'hFFFF_FFFF, "R5");
    pulse();
    expect_rd(4'd1, 32'h0000_0007, "R5");
    expect_rd(4'd0, 32'h0000_0000, "R5");
    expect_rd(4'd1, 32'h0000_0008, "R5");

    // R3: full 64-bit wrap
    cur_req = "R3";
    bus(1'b1, 4'd1, 32'hFFFF_FFFF);
    bus(1'b1, 4'd0, 32'hFFFF_FFFF);
    pulse();
    expect_rd(4'd0, 32'd0, "R3");
    expect_rd(4'd1, 32'd0, "R3");

    // R4: write lands in the same cycle as a tick edge, write wins
    cur_req = "R4";
    @(posedge clk); #1; tick_in = 1'b1;
    @(posedge clk);
    bus(1'b1, 4'd0, 32'h0000_0100);
    tick_in = 1'b0;
    idle(4);
    expect_rd(4'd0, 32'h0000_0100, "R4");

    // R6, R11, R9: two references on the same value
    cur_req = "R6";
    bus(1'b1, 4'd4, 32'h0000_0102);
    bus(1'b1, 4'd6, 32'h0000_0102);
    bus(1'b1, 4'd2, 32'h0000_000F);
    bus(1'b1, 4'd3, 32'h0000_0101);
    expect_irq(1'b0, "R9");
    pulse();
    pulse();
    expect_rd(4'd2, 32'h3, "R11");
    expect_irq(1'b1, "R9");

    // R8: writing zero keeps bits, writing one clears
    cur_req = "R8";
    bus(1'b1, 4'd2, 32'h0);
    expect_rd(4'd2, 32'h3, "R8");
    bus(1'b1, 4'd2, 32'h1);
    expect_rd(4'd2, 32'h2, "R8");
    expect_irq(1'b0, "R9");

    // R9: without the global enable nothing reaches irq
    cur_req = "R9";
    bus(1'b1, 4'd3, 32'h0000_000F);
    expect_irq(1'b0, "R9");
    bus(1'b1, 4'd3, 32'h0000_010F);
    expect_irq(1'b1, "R9");

    // R7: reference loaded with the static counter value
    cur_req = "R7";
    bus(1'b1, 4'd8, 32'h0000_0102);
    idle(5);
    expect_rd(4'd2, 32'h2, "R7");
    // R6: a counter write counts as an update
    cur_req = "R6";
    pulse();
    pulse();
    bus(1'b1, 4'd0, 32'h0000_0102);
    idle(2);
    expect_rd(4'd2, 32'h7, "R6");

    // R10: read-back and unmapped space
    cur_req = "R10";
    expect_rd(4'd8, 32'h0000_0102, "R10");
    expect_rd(4'd9, 32'h0, "R10");
    expect_rd(4'd3, 32'h0000_010F, "R10");
    bus(1'b1, 4'd13, 32'hFFFF_FFFF);
    expect_rd(4'd13, 32'h0, "R10");
    expect_rd(4'd2, 32'h7, "R10");

    // R11: mixed random traffic against the model
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) tick_in = ~tick_in;
      if ($urandom_range(0, 2) == 0) begin
        reg_en    = 1'b1;
        reg_we    = ($urandom_range(0, 3) == 0);
        reg_addr  = 4'($urandom_range(0, 15));
        reg_wdata = (reg_addr == 4'd3) ? 32'h0000_010F : 32'($urandom_range(0, 24));
      end else begin
        reg_en = 1'b0;
        reg_we = 1'b0;
      end
    end
    reg_en = 1'b0;
    reg_we = 1'b0;
    idle(4);

    finish_run();
  end
endmodule